// File: doc/BRIEF.md
# Ternary Prefix Route Lookup Table

This block is a small route table searched by content. Each entry holds a key pattern, a per-bit compare mask, a valid flag and a next-hop word. A search key is compared against every entry at once. The block reports whether any entry matched, which entry won and the next-hop word stored with that entry. All three results are combinational and appear in the same cycle as the key.

A mask bit of 1 means that key bit must equal the stored pattern bit. A mask bit of 0 means the position matches either key value, so the low bits of a prefix can be ignored. When several entries match, the lowest index wins. Software gets longest-prefix results by storing longer prefixes at lower indices than the shorter prefixes they overlap. A default route is an entry with an all-zero mask placed at the highest index.

Software fills the table one entry per clock through the write port. A synchronous flush input clears every valid flag, and so does the active-low reset.

Top module: `route_tcam_lookup`

## Requirements
- R1: An entry matches when ((pattern XOR key) AND mask) is all zeros. A mask bit of 1 forces an exact compare at that position, and a mask bit of 0 accepts either key value there.
- R2: An entry whose valid flag is clear never matches. Reset (rst_n low) clears every valid flag.
- R3: Match, hit, index and next-hop respond combinationally to the key in the same cycle, with no clock edge in between.
- R4: `hit` is 1 exactly when at least one valid entry matches the key.
- R5: When more than one entry matches, `hit_idx` is the lowest matching index.
- R6: On a miss, `hit_idx` is 0 and `next_hop` is all zeros.
- R7: A write with `wr_en` high stores pattern, mask and next-hop at `wr_idx` on the rising edge and sets that entry valid. A search in the cycle of the write sees the old contents, and the new contents are visible from the following cycle on. A rewrite replaces the old pattern.
- R8: `flush` clears every valid flag at the rising edge. When `flush` and `wr_en` are high in the same cycle, the flush wins and no entry is left valid.
- R9: With longer prefixes at lower indices and an all-zero-mask entry at the highest index, a key gets the longest matching prefix, and a key that matches no prefix falls through to the default entry.
- R10: On a hit, `next_hop` equals the next-hop word most recently written to entry `hit_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| flush | input | 1 | Synchronous clear of all valid flags; has priority over a write |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | $clog2(ENTRIES) | Entry index to write |
| wr_pattern | input | KEY_W | Pattern bits to store |
| wr_mask | input | KEY_W | Compare mask: 1 = must equal, 0 = don't care |
| wr_hop | input | HOP_W | Next-hop word to store |
| key | input | KEY_W | Search key |
| hit | output | 1 | At least one valid entry matches |
| hit_idx | output | $clog2(ENTRIES) | Lowest matching index; 0 on a miss |
| next_hop | output | HOP_W | Next-hop word of the winning entry; 0 on a miss |

## Verification
The bench loads a nested set of prefixes (/32, /24, /16, /8) plus one entry whose mask is not a prefix and a default route. It then sweeps keys that should land on each depth of that nest. If priority resolved toward the highest index, or toward the entry with the fewest care bits, keys would land on a shorter prefix or on the default route. One key matches both the /8 entry and the non-prefix entry, which catches an encoder that picks anything other than the lowest index. A key that differs from the non-prefix entry only in one care bit catches an inverted mask sense. Directed tests search during a write, where a design with a bypass would show the new entry one cycle early. They also assert flush together with a write, where a design that ordered the write after the flush would leave a stray valid entry. Finally they rewrite entry 0, where a design that kept a stale pattern would still hit the old key.

// File: rtl/route_tcam_pkg.sv
package route_tcam_pkg;

  localparam int DEF_ENTRIES = 16;
  localparam int DEF_KEY_W   = 32;
  localparam int DEF_HOP_W   = 8;

  // Width of an entry index; never below one bit.
  function automatic int idx_width(input int entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction

endpackage

// File: rtl/route_tcam_store.sv
module route_tcam_store #(
  parameter int ENTRIES = route_tcam_pkg::DEF_ENTRIES,
  parameter int KEY_W   = route_tcam_pkg::DEF_KEY_W,
  parameter int HOP_W   = route_tcam_pkg::DEF_HOP_W,
  localparam int IW     = route_tcam_pkg::idx_width(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            wr_en,
  input  logic [IW-1:0]                   wr_idx,
  input  logic [KEY_W-1:0]                wr_pattern,
  input  logic [KEY_W-1:0]                wr_mask,
  input  logic [HOP_W-1:0]                wr_hop,
  output logic [ENTRIES-1:0]              valid_q,
  output logic [ENTRIES-1:0][KEY_W-1:0]   pattern_q,
  output logic [ENTRIES-1:0][KEY_W-1:0]   mask_q,
  output logic [ENTRIES-1:0][HOP_W-1:0]   hop_q
);

  // A write commits only when no flush is pending in the same cycle.
  logic commit_wr;
  assign commit_wr = wr_en && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_wr) begin
      pattern_q[wr_idx] <= wr_pattern;
      mask_q[wr_idx]    <= wr_mask;
      hop_q[wr_idx]     <= wr_hop;
    end
  end

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  a_r7_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> valid_q[$past(wr_idx)]);

  a_r10_hop_stored: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> (hop_q[$past(wr_idx)] == $past(wr_hop)));

endmodule

// File: rtl/route_tcam_compare.sv
module route_tcam_compare #(
  parameter int ENTRIES = route_tcam_pkg::DEF_ENTRIES,
  parameter int KEY_W   = route_tcam_pkg::DEF_KEY_W
) (
  input  logic [KEY_W-1:0]                key,
  input  logic [ENTRIES-1:0]              valid_q,
  input  logic [ENTRIES-1:0][KEY_W-1:0]   pattern_q,
  input  logic [ENTRIES-1:0][KEY_W-1:0]   mask_q,
  output logic [ENTRIES-1:0]              match_vec
);

  // Differing bits that the mask cares about; none left means a match.
  function automatic logic care_bits_agree(
    input logic [KEY_W-1:0] pat,
    input logic [KEY_W-1:0] msk,
    input logic [KEY_W-1:0] k
  );
    return ((pat ^ k) & msk) == '0;
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_line
    assign match_vec[e] = valid_q[e] && care_bits_agree(pattern_q[e], mask_q[e], key);
  end

endmodule

// File: rtl/route_tcam_prio.sv
module route_tcam_prio #(
  parameter int ENTRIES = route_tcam_pkg::DEF_ENTRIES,
  localparam int IW     = route_tcam_pkg::idx_width(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output logic [IW-1:0]      win_idx
);

  // Index of the lowest set bit, zero when none is set.
  function automatic logic [IW-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any_match = |match_vec;
  assign win_idx   = lowest_set(match_vec);

endmodule

// File: rtl/route_tcam_lookup.sv
module route_tcam_lookup #(
  parameter int ENTRIES = route_tcam_pkg::DEF_ENTRIES,
  parameter int KEY_W   = route_tcam_pkg::DEF_KEY_W,
  parameter int HOP_W   = route_tcam_pkg::DEF_HOP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [KEY_W-1:0]            wr_pattern,
  input  logic [KEY_W-1:0]            wr_mask,
  input  logic [HOP_W-1:0]            wr_hop,
  input  logic [KEY_W-1:0]            key,
  output logic                        hit,
  output logic [$clog2(ENTRIES)-1:0]  hit_idx,
  output logic [HOP_W-1:0]            next_hop
);

  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][KEY_W-1:0] pattern_q;
  logic [ENTRIES-1:0][KEY_W-1:0] mask_q;
  logic [ENTRIES-1:0][HOP_W-1:0] hop_q;
  logic [ENTRIES-1:0]            match_vec;

  route_tcam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .HOP_W(HOP_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_pattern (wr_pattern),
    .wr_mask    (wr_mask),
    .wr_hop     (wr_hop),
    .valid_q    (valid_q),
    .pattern_q  (pattern_q),
    .mask_q     (mask_q),
    .hop_q      (hop_q)
  );

  route_tcam_compare #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_cmp (
    .key        (key),
    .valid_q    (valid_q),
    .pattern_q  (pattern_q),
    .mask_q     (mask_q),
    .match_vec  (match_vec)
  );

  route_tcam_prio #(.ENTRIES(ENTRIES)) u_prio (
    .match_vec  (match_vec),
    .any_match  (hit),
    .win_idx    (hit_idx)
  );

  // Payload read from the parallel array, gated to zero on a miss.
  assign next_hop = hit ? hop_q[hit_idx] : '0;

  // Mask of all indices strictly below the winner.
  logic [ENTRIES-1:0] below_win;
  assign below_win = ({{(ENTRIES-1){1'b0}}, 1'b1} << hit_idx) - {{(ENTRIES-1){1'b0}}, 1'b1};

  a_r5_winner_matches: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx]);

  a_r5_none_below: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & below_win) == '0));

  a_r6_miss_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (next_hop == '0 && hit_idx == '0));

  a_r2_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |-> !hit);

  a_r8_after_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  a_r10_payload_of_winner: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (next_hop == hop_q[hit_idx]));

  logic unused_iw;
  assign unused_iw = (IW == 0);

endmodule

// File: tb/route_tcam_lookup_bench.sv
`timescale 1ns/1ps
module route_tcam_lookup_bench;

  localparam int ENTRIES = 16;
  localparam int KEY_W   = 32;
  localparam int HOP_W   = 8;
  localparam int IW      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0]    wr_idx = '0;
  logic [KEY_W-1:0] wr_pattern = '0;
  logic [KEY_W-1:0] wr_mask = '0;
  logic [HOP_W-1:0] wr_hop = '0;
  logic [KEY_W-1:0] key = '0;
  logic             hit;
  logic [IW-1:0]    hit_idx;
  logic [HOP_W-1:0] next_hop;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  route_tcam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .HOP_W(HOP_W)) u_route_tcam_lookup (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_pattern(wr_pattern), .wr_mask(wr_mask), .wr_hop(wr_hop), .key(key),
    .hit(hit), .hit_idx(hit_idx), .next_hop(next_hop)
  );

  // Route table: nested prefixes at low indices, a non-prefix mask at 5.
  localparam int NLOAD = 6;
  localparam logic [3:0]  LD_IDX [NLOAD] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5};
  localparam logic [31:0] LD_PAT [NLOAD] = '{32'h0A010203, 32'h0A010200, 32'h0A010000,
                                             32'h0A000000, 32'hC0A80000, 32'h00000005};
  localparam logic [31:0] LD_MSK [NLOAD] = '{32'hFFFFFFFF, 32'hFFFFFF00, 32'hFFFF0000,
                                             32'hFF000000, 32'hFFFF0000, 32'h0000000F};
  localparam logic [7:0]  LD_HOP [NLOAD] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};

  // Search vectors against the table plus the default route at 15.
  localparam int NVEC = 9;
  localparam logic [31:0] V_KEY [NVEC] = '{32'h0A010203, 32'h0A0102FF, 32'h0A01FF00,
                                           32'h0AFFFFFF, 32'hC0A81234, 32'h12345675,
                                           32'h0A000005, 32'hFFFFFFF0, 32'h12345674};
  localparam logic [3:0]  V_IDX [NVEC] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd3, 4'd15, 4'd15};
  localparam logic [7:0]  V_HOP [NVEC] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
                                           8'h44, 8'h77, 8'h77};

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic expect_result(input string req, input logic e_hit,
                               input logic [IW-1:0] e_idx, input logic [HOP_W-1:0] e_hop);
    n_checks++;
    if (hit !== e_hit || hit_idx !== e_idx || next_hop !== e_hop) begin
      n_fails++;
      $display("FAIL %s key=%h: got hit=%b idx=%0d hop=%h, expected hit=%b idx=%0d hop=%h",
               req, key, hit, hit_idx, next_hop, e_hit, e_idx, e_hop);
    end
  endtask

  task automatic write_entry(input logic [IW-1:0] idx, input logic [KEY_W-1:0] pat,
                             input logic [KEY_W-1:0] msk, input logic [HOP_W-1:0] hop);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_pattern = pat; wr_mask = msk; wr_hop = hop;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic search(input logic [KEY_W-1:0] k);
    @(negedge clk);
    key = k;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R2 / R6: empty table after reset misses with zero outputs
    search(32'h00000000);
    expect_result("R2", 1'b0, '0, '0);
    @(negedge clk) rst_n = 1'b1;
    search(32'h0A010203);
    expect_result("R6", 1'b0, '0, '0);

    for (int i = 0; i < NLOAD; i++)
      write_entry(LD_IDX[i], LD_PAT[i], LD_MSK[i], LD_HOP[i]);

    // R6: no default route yet, unmatched key misses
    search(32'hFFFFFFF0);
    expect_result("R6", 1'b0, '0, '0);
    // R9: default route, all-zero mask, highest index
    write_entry(4'd15, 32'h00000000, 32'h00000000, 8'h77);

    // R1 R3 R4 R5 R9 R10: table walk
    for (int v = 0; v < NVEC; v++) begin
      search(V_KEY[v]);
      expect_result("R1/R5/R9/R10", 1'b1, V_IDX[v], V_HOP[v]);
    end

    // R7: search in the write cycle sees the old table
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd6; wr_pattern = 32'hDEADBEEF;
    wr_mask = 32'hFFFFFFFF; wr_hop = 8'h99; key = 32'hDEADBEEF;
    #1;
    expect_result("R7", 1'b1, 4'd15, 8'h77);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    expect_result("R7", 1'b1, 4'd6, 8'h99);

    // R7: rewrite entry 0; the old exact key drops to the /24
    write_entry(4'd0, 32'h01020304, 32'hFFFFFFFF, 8'hA5);
    search(32'h0A010203);
    expect_result("R7", 1'b1, 4'd1, 8'h22);
    search(32'h01020304);
    expect_result("R7", 1'b1, 4'd0, 8'hA5);

    // R8: flush with a simultaneous write leaves nothing valid
    @(negedge clk);
    flush = 1'b1; wr_en = 1'b1; wr_idx = 4'd7;
    wr_pattern = 32'h55AA55AA; wr_mask = 32'hFFFFFFFF; wr_hop = 8'hBB;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
    search(32'h55AA55AA);
    expect_result("R8", 1'b0, '0, '0);
    search(32'hFFFFFFF0);
    expect_result("R8", 1'b0, '0, '0);

    // R2: reset clears valid flags after a fresh write
    write_entry(4'd3, 32'h12340000, 32'hFFFF0000, 8'hC3);
    search(32'h1234ABCD);
    expect_result("R4", 1'b1, 4'd3, 8'hC3);
    @(negedge clk) rst_n = 1'b0;
    #1;
    expect_result("R2", 1'b0, '0, '0);
    @(negedge clk) rst_n = 1'b1;

    report();
    $finish;
  end

endmodule